// File: doc/BRIEF.md
# Oscillator Pull-Word Frame Sequencer

This block turns a signed frequency-control word into the ordered register-write frames that retune a digitally controlled oscillator. A request carries the word, already rounded and in two's complement, and a flag that picks the narrow (16-bit) or the wide (23-bit) format. The narrow format needs one write. The wide format splits the word across two registers. The write that holds the low bits goes out first, because only the write of the high bits commits the new frequency.

Each frame is a 40-bit parallel word. It goes to a downstream serial encoder over a valid/ready stream. The block holds every frame, unchanged, until the encoder takes it. After each accepted frame the block waits one frame slot before it offers anything else. The slot covers the serial transmission of 40 bit periods plus a minimum idle gap of `GAP_BITS` bit periods, and each bit period is `BIT_CYCLES` clocks long.

Back-pressure works in both directions. On the request side, `req_ready` is high only while the block is idle. A request that arrives while a sequence is running waits, with `req_ready` low, until that sequence and its trailing slot are over. On the frame side, the encoder may hold `frm_ready` low for as long as it needs. A transfer takes place on any rising clock edge where valid and ready are both high.

Top module: `pull_frame_seq`

## Requirements
- R1: Each frame carries the sync pattern 0xFA0A in bits 39:24, the register address in bits 23:16 and the data word in bits 15:0.
- R2: When `req_wide` is 0, the sequence is exactly one frame, to address 0x06, whose data is `req_word[15:0]`. Bits 22:16 of the word have no effect on that frame.
- R3: When `req_wide` is 1, the sequence is two frames. The first goes to address 0x07 with data `{9'b0, req_word[6:0]}`, so data bits 15:7 are zero. The second goes to address 0x06 with data `req_word[22:7]`.
- R4: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_data` does not change.
- R5: After a frame is accepted on edge E, the next frame of the same sequence is first offered in the cycle after edge E+(40+GAP_BITS)*BIT_CYCLES.
- R6: A request is taken on an edge where `req_valid` and `req_ready` are both high. The first frame is offered in the very next cycle.
- R7: `busy` is high and `req_ready` is low from the cycle after a request is taken until the sequence completes. A request presented during that time is not taken.
- R8: `done` is high for exactly one cycle, the cycle after edge E+(40+GAP_BITS)*BIT_CYCLES, where E is the edge that accepted the last frame. In the following cycle `req_ready` is high and `busy` is low.
- R9: While reset is held and after it is released, `req_ready` is 1 and `busy`, `done` and `frm_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, high only when idle |
| req_wide | input | 1 | 1 selects the 23-bit two-frame format, 0 the 16-bit single frame |
| req_word | input | 23 | Two's-complement control word |
| frm_valid | output | 1 | Frame stream valid |
| frm_ready | input | 1 | Frame stream ready from the encoder |
| frm_data | output | 40 | Frame: sync, address, data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Every result has a fixed due cycle. The first frame appears in the cycle right after the request is taken. Each later frame appears exactly one slot of (40+GAP_BITS)*BIT_CYCLES cycles after the edge that accepted the frame before it. `done` falls on that same slot boundary after the last frame, and `req_ready` returns one cycle later. The bench drives inputs and samples outputs on the falling edge, keeps a count of rising edges, and compares the count at first sight of each event with the due value. Any shift of even one cycle is therefore reported. Stalls from the encoder are inserted, and the bench confirms that they push the slot back from the later acceptance edge rather than from the first offer.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int SYNC_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = SYNC_W + ADDR_W + DATA_W;
  localparam int WORD_W  = 23;
  localparam int LOW_W   = WORD_W - DATA_W;

  localparam logic [SYNC_W-1:0] SYNC_PATTERN = 16'hFA0A;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT  = 8'h06;
  localparam logic [ADDR_W-1:0] ADDR_LOWPART = 8'h07;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SEND = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [SYNC_W-1:0] sync;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/pfs_frame_builder.sv
module pfs_frame_builder
  import pfs_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               wide,
  input  logic               low_part,
  output logic [FRAME_W-1:0] frame
);
  frame_t f;

  always_comb begin
    f.sync = SYNC_PATTERN;
    if (wide && low_part) begin
      f.addr = ADDR_LOWPART;
      f.data = {{(DATA_W-LOW_W){1'b0}}, word[LOW_W-1:0]};
    end else if (wide) begin
      f.addr = ADDR_COMMIT;
      f.data = word[WORD_W-1:LOW_W];
    end else begin
      f.addr = ADDR_COMMIT;
      f.data = word[DATA_W-1:0];
    end
  end

  assign frame = f;
endmodule

// File: rtl/pfs_slot_timer.sv
module pfs_slot_timer #(
  parameter int SLOT_CYC = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = $clog2(SLOT_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CNT_W'(SLOT_CYC);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == CNT_W'(1));

  // R5: a new slot never starts while one is still running
  slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt == '0));
endmodule

// File: rtl/pfs_seq_ctrl.sv
module pfs_seq_ctrl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       req_wide,
  input  logic       frm_fire,
  input  logic       slot_expired,
  output seq_state_t state,
  output logic       low_part,
  output logic       slot_start
);
  seq_state_t nxt;
  logic       low_nxt;

  always_comb begin
    nxt     = state;
    low_nxt = low_part;
    case (state)
      SEQ_IDLE: if (req_fire) begin
        nxt     = SEQ_SEND;
        low_nxt = req_wide;
      end
      SEQ_SEND: if (frm_fire) nxt = SEQ_WAIT;
      SEQ_WAIT: if (slot_expired) begin
        if (low_part) begin
          nxt     = SEQ_SEND;
          low_nxt = 1'b0;
        end else begin
          nxt = SEQ_DONE;
        end
      end
      SEQ_DONE: nxt = SEQ_IDLE;
      default:  nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      low_part <= 1'b0;
    end else begin
      state    <= nxt;
      low_part <= low_nxt;
    end
  end

  assign slot_start = (state == SEQ_SEND) && frm_fire;

  // R8: completion state lasts a single cycle
  done_state_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DONE) |=> (state == SEQ_IDLE));
  // R3: the low-part frame is always followed by another frame, never completion
  low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT && low_part) |=> (state != SEQ_DONE));
endmodule

// File: rtl/pull_frame_seq.sv
module pull_frame_seq
  import pfs_pkg::*;
#(
  parameter int BIT_CYCLES = 4,
  parameter int GAP_BITS   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_wide,
  input  logic [WORD_W-1:0]  req_word,
  output logic               frm_valid,
  input  logic               frm_ready,
  output logic [FRAME_W-1:0] frm_data,
  output logic               busy,
  output logic               done
);
  localparam int SLOT_CYC = (FRAME_W + GAP_BITS) * BIT_CYCLES;
  localparam int CHK_W    = $clog2(SLOT_CYC + 1);

  seq_state_t        state;
  logic              low_part;
  logic              slot_start;
  logic              slot_expired;
  logic              req_fire;
  logic              frm_fire;
  logic [WORD_W-1:0] word_q;
  logic              wide_q;

  assign req_ready = (state == SEQ_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign frm_valid = (state == SEQ_SEND);
  assign frm_fire  = frm_valid && frm_ready;
  assign busy      = (state != SEQ_IDLE);
  assign done      = (state == SEQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      wide_q <= 1'b0;
    end else if (req_fire) begin
      word_q <= req_word;
      wide_q <= req_wide;
    end
  end

  pfs_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .req_wide     (req_wide),
    .frm_fire     (frm_fire),
    .slot_expired (slot_expired),
    .state        (state),
    .low_part     (low_part),
    .slot_start   (slot_start)
  );

  pfs_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (slot_start),
    .expired (slot_expired)
  );

  pfs_frame_builder u_build (
    .word     (word_q),
    .wide     (wide_q),
    .low_part (low_part),
    .frame    (frm_data)
  );

  // cycles since the last frame transfer, saturating, for the spacing check
  logic [CHK_W-1:0] since_xfer;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_xfer <= CHK_W'(SLOT_CYC);
    else if (frm_fire)                       since_xfer <= '0;
    else if (since_xfer != CHK_W'(SLOT_CYC)) since_xfer <= since_xfer + 1'b1;
  end

  // R4
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data)));
  // R5
  slot_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_valid) |-> (since_xfer == CHK_W'(SLOT_CYC)));
  // R7
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R1
  sync_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_data[FRAME_W-1:FRAME_W-SYNC_W] == SYNC_PATTERN));
  // R3
  low_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_data[DATA_W+ADDR_W-1:DATA_W] == ADDR_LOWPART)
      |-> (frm_data[DATA_W-1:LOW_W] == '0));
  // R6
  first_frame_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> frm_valid);
endmodule

// File: tb/test_pull_frame_seq.sv
module test_pull_frame_seq;
  localparam int BITC = 4;
  localparam int GAPB = 2;
  localparam int SLOT = (40 + GAPB) * BITC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wide = 1'b0;
  logic [22:0] req_word = '0;
  logic        frm_valid;
  logic        frm_ready = 1'b0;
  logic [39:0] frm_data;
  logic        busy;
  logic        done;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pull_frame_seq #(.BIT_CYCLES(BITC), .GAP_BITS(GAPB)) i_pull_frame_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_word(req_word),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input bit wide, input logic [22:0] w, output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_wide  = wide;
    req_word  = w;
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", "first frame offered right after request", {63'd0, frm_valid}, 64'd1);
    chk("R7", "busy after request", {62'd0, busy, req_ready}, 64'd2);
  endtask

  task automatic take_frame(input int stall, input int ref_cyc, input int delay,
                            output logic [39:0] f, output int acc);
    int guard = 0;
    while (!frm_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R5", "frame offer cycle", 64'(cyc - ref_cyc), 64'(delay));
    f = frm_data;
    for (int i = 0; i < stall; i++) @(negedge clk);
    if (stall > 0)
      chk("R4", "frame held under stall", {23'd0, frm_valid, frm_data}, {23'd0, 1'b1, f});
    frm_ready = 1'b1;
    acc = cyc + 1;
    @(negedge clk);
    frm_ready = 1'b0;
  endtask

  task automatic wait_done(input int last_acc);
    int  guard = 0;
    bit  viol = 0;
    bit  extra = 0;
    while (!done && guard < 2000) begin
      if (req_ready || !busy) viol = 1;
      if (frm_valid) extra = 1;
      @(negedge clk);
      guard++;
    end
    chk("R7", "busy held and ready low during sequence", {63'd0, viol}, 64'd0);
    chk("R2", "no extra frame in sequence", {63'd0, extra}, 64'd0);
    chk("R8", "done cycle after last accept", 64'(cyc - last_acc), 64'(SLOT));
    @(negedge clk);
    chk("R8", "after done: ready, idle, done low",
        {61'd0, req_ready, busy, done}, 64'd4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "outputs in reset", {60'd0, req_ready, busy, done, frm_valid}, 64'd8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "outputs after reset", {60'd0, req_ready, busy, done, frm_valid}, 64'd8);
  endtask

  task automatic t_narrow(input logic [22:0] w, input int stall);
    int a0, a1;
    logic [39:0] f;
    send_req(1'b0, w, a0);
    take_frame(stall, a0, 0, f, a1);
    chk("R1", "narrow frame sync", {48'd0, f[39:24]}, 64'hFA0A);
    chk("R2", "narrow frame addr/data", {40'd0, f[23:0]}, {40'd0, 8'h06, w[15:0]});
    wait_done(a1);
  endtask

  task automatic t_wide(input logic [22:0] w, input logic [15:0] lo,
                        input logic [15:0] hi, input int stall);
    int a0, a1, a2;
    logic [39:0] f;
    send_req(1'b1, w, a0);
    take_frame(stall, a0, 0, f, a1);
    chk("R3", "wide first frame (low part)", {24'd0, f}, {24'd0, 16'hFA0A, 8'h07, lo});
    take_frame(0, a1, SLOT, f, a2);
    chk("R3", "wide second frame (commit)", {24'd0, f}, {24'd0, 16'hFA0A, 8'h06, hi});
    wait_done(a2);
  endtask

  task automatic t_busy_hold();
    int a0, a1, a2, a3;
    logic [39:0] f;
    send_req(1'b1, 23'h09CF8A, a0);
    req_valid = 1'b1;
    req_wide  = 1'b0;
    req_word  = 23'h00ABCD;
    take_frame(0, a0, 0, f, a1);
    chk("R7", "held request ignored, first frame", {24'd0, f}, 64'hFA0A07000A);
    take_frame(0, a1, SLOT, f, a2);
    chk("R7", "held request ignored, second frame", {24'd0, f}, 64'hFA0A06139F);
    wait_done(a2);
    // held request is taken on the edge after ready returns
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", "held request taken after idle", {63'd0, frm_valid}, 64'd1);
    take_frame(0, cyc, 0, f, a3);
    chk("R2", "held narrow request frame", {24'd0, f}, 64'hFA0A06ABCD);
    wait_done(a3);
  endtask

  initial begin
    t_reset();
    t_narrow(23'h7F1234, 0);
    t_narrow(23'h00FFFF, 5);
    t_wide(23'h09CF8A, 16'h000A, 16'h139F, 0);
    t_wide(23'h5ECC0B, 16'h000B, 16'hBD98, 3);
    t_wide(23'h7FFFFF, 16'h007F, 16'hFFFF, 1);
    t_busy_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule